// File: doc/BRIEF.md
# Sequential Single-Precision Floating-Point Multiplier

This block multiplies two IEEE-754 single-precision numbers over a fixed number of clock cycles. A caller presents both operands with a one-cycle `start` strobe while the unit is idle. The unit then takes the exponent sum and removes one bias. It forms the 48-bit product of the two 24-bit significands with an iterative shift-add loop, one multiplier bit per cycle. It normalizes that product, rounds it to nearest-even and renormalizes if the rounding carries out. As a last step it attaches the sign.

The result word and two range flags (overflow, underflow) appear together with a one-cycle `done` pulse. They hold until the next operation completes. An exponent field of zero is read as a zero operand. NaN, infinity and denormal encodings are not given special treatment, and round-to-nearest-even is the only rounding mode.

Top module: `fp_mul_seq`

## Requirements
- R1: For nonzero operands, the result exponent field equals expA + expB − 127. It is raised by one when the product of the two significands (each with its hidden one) is 2 or more, in which case the product is shifted right one place. The 23 stored fraction bits are the product's bits below its leading one.
- R2: The discarded product bits are rounded to nearest with ties going to the even fraction. If rounding overflows the significand to 2.0, the result becomes 1.0 with the exponent raised by one.
- R3: Result bit 31 is the XOR of operand bits 31 in every outcome, including zero, overflow and underflow results.
- R4: If either operand's exponent field (bits 30:23) is zero, the result is a zero (bits 30:0 all zero) with both flags low.
- R5: If the final exponent is 255 or more, `ovf` is set and bits 30:0 read 0x7F800000 (infinity). A final exponent of 254 is a normal result.
- R6: If the final exponent is 0 or less, `unf` is set and bits 30:0 are zero. A final exponent of 1 is a normal result.
- R7: `done` is high for exactly one cycle, 28 cycles after the edge that accepts `start`. `busy` is high from the cycle after acceptance until the cycle in which `done` is high, where it reads low.
- R8: A `start` strobe while `busy` is high is ignored. The running operation finishes with its own operands.
- R9: After reset, `busy`, `done`, `result`, `ovf` and `unf` are all zero.
- R10: `result`, `ovf` and `unf` change only on the edge that raises `done`. They hold their values in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation (taken only while idle) |
| opA | input | 32 | First operand, single precision |
| opB | input | 32 | Second operand, single precision |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: result and flags updated |
| result | output | 32 | Product, single precision |
| ovf | output | 1 | Exponent overflow on the last result |
| unf | output | 1 | Exponent underflow on the last result |

## Verification
A wrong sequencer state or loop count shows at the ports as a `done` pulse in the wrong cycle or a `busy` that stays high. The per-cycle reference comparison catches it on the first cycle it differs. A fault in the shift-add loop or the exponent register stays hidden until the 28th cycle. It then appears as a wrong fraction, exponent or flag in the same cycle `done` rises. Rounding and renormalization faults appear only for operands whose discarded bits sit at or just above one half, so tie cases and an all-ones carry-out case are driven on purpose.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef struct packed {
    logic ldOps;
    logic expStep;
    logic mulStep;
    logic normStep;
    logic rndStep;
    logic finStep;
  } fpmStrobes_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_EXP,
    S_MUL,
    S_NORM,
    S_RND,
    S_FIN
  } fpmState_t;

endpackage

// File: rtl/fpm_ctrl.sv
module fpm_ctrl
  import fpm_pkg::*;
#(
  parameter int MAN_W = 24
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output fpmStrobes_t stb,
  output logic        busy
);

  localparam int CNT_W = $clog2(MAN_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(MAN_W - 1);

  fpmState_t        state;
  logic [CNT_W-1:0] bitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      bitCnt <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) state <= S_EXP;
        S_EXP: begin
          state  <= S_MUL;
          bitCnt <= '0;
        end
        S_MUL: begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == LAST_BIT) state <= S_NORM;
        end
        S_NORM:  state <= S_RND;
        S_RND:   state <= S_FIN;
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb          = '0;
    stb.ldOps    = (state == S_IDLE) && start;
    stb.expStep  = (state == S_EXP);
    stb.mulStep  = (state == S_MUL);
    stb.normStep = (state == S_NORM);
    stb.rndStep  = (state == S_RND);
    stb.finStep  = (state == S_FIN);
    busy         = (state != S_IDLE);
  end

endmodule

// File: rtl/fpm_dpath.sv
module fpm_dpath
  import fpm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  fpmStrobes_t             stb,
  input  logic [EXP_W+FRAC_W:0]   opA,
  input  logic [EXP_W+FRAC_W:0]   opB,
  output logic                    done,
  output logic [EXP_W+FRAC_W:0]   result,
  output logic                    ovf,
  output logic                    unf
);

  localparam int MAN_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * MAN_W;
  localparam int XE_W   = EXP_W + 2;
  localparam int SGN_B  = EXP_W + FRAC_W;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam logic signed [XE_W-1:0] EXP_TOP = XE_W'((1 << EXP_W) - 1);
  localparam logic signed [XE_W-1:0] ONE     = XE_W'(1);
  localparam logic signed [XE_W-1:0] ZERO    = '0;

  logic                    sgnA, sgnB;
  logic [EXP_W-1:0]        expA, expB;
  logic [MAN_W-1:0]        manA;
  logic [PROD_W-1:0]       prod;
  logic signed [XE_W-1:0]  expAcc;
  logic                    isZero;
  logic [MAN_W-1:0]        mant;
  logic                    guardBit, roundBit, stickyBit;

  logic [MAN_W:0]          partSum;
  logic                    roundUp;
  logic [MAN_W:0]          rndSum;
  logic                    resSign;

  always_comb begin
    partSum = {1'b0, prod[PROD_W-1:MAN_W]} + (prod[0] ? {1'b0, manA} : '0);
    roundUp = guardBit & (roundBit | stickyBit | mant[0]);
    rndSum  = {1'b0, mant} + {{MAN_W{1'b0}}, roundUp};
    resSign = sgnA ^ sgnB;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sgnA      <= 1'b0;
      sgnB      <= 1'b0;
      expA      <= '0;
      expB      <= '0;
      manA      <= '0;
      prod      <= '0;
      expAcc    <= '0;
      isZero    <= 1'b0;
      mant      <= '0;
      guardBit  <= 1'b0;
      roundBit  <= 1'b0;
      stickyBit <= 1'b0;
      done      <= 1'b0;
      result    <= '0;
      ovf       <= 1'b0;
      unf       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (stb.ldOps) begin
        sgnA <= opA[SGN_B];
        sgnB <= opB[SGN_B];
        expA <= opA[FRAC_W +: EXP_W];
        expB <= opB[FRAC_W +: EXP_W];
        manA <= {1'b1, opA[FRAC_W-1:0]};
        prod <= {{MAN_W{1'b0}}, 1'b1, opB[FRAC_W-1:0]};
      end
      if (stb.expStep) begin
        expAcc <= XE_W'(expA) + XE_W'(expB) - XE_W'(BIAS);
        isZero <= (expA == '0) || (expB == '0);
      end
      if (stb.mulStep) begin
        prod <= {partSum, prod[MAN_W-1:1]};
      end
      if (stb.normStep) begin
        if (prod[PROD_W-1]) begin
          mant      <= prod[PROD_W-1 -: MAN_W];
          guardBit  <= prod[MAN_W-1];
          roundBit  <= prod[MAN_W-2];
          stickyBit <= |prod[MAN_W-3:0];
          expAcc    <= expAcc + ONE;
        end else begin
          mant      <= prod[PROD_W-2 -: MAN_W];
          guardBit  <= prod[MAN_W-2];
          roundBit  <= prod[MAN_W-3];
          stickyBit <= |prod[MAN_W-4:0];
        end
      end
      if (stb.rndStep) begin
        if (rndSum[MAN_W]) begin
          mant   <= rndSum[MAN_W:1];
          expAcc <= expAcc + ONE;
        end else begin
          mant <= rndSum[MAN_W-1:0];
        end
      end
      if (stb.finStep) begin
        done <= 1'b1;
        ovf  <= 1'b0;
        unf  <= 1'b0;
        if (isZero) begin
          result <= {resSign, {(EXP_W+FRAC_W){1'b0}}};
        end else if (expAcc >= EXP_TOP) begin
          result <= {resSign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
          ovf    <= 1'b1;
        end else if (expAcc <= ZERO) begin
          result <= {resSign, {(EXP_W+FRAC_W){1'b0}}};
          unf    <= 1'b1;
        end else begin
          result <= {resSign, expAcc[EXP_W-1:0], mant[FRAC_W-1:0]};
        end
      end
    end
  end

endmodule

// File: rtl/fp_mul_seq.sv
module fp_mul_seq
  import fpm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [EXP_W+FRAC_W:0] opA,
  input  logic [EXP_W+FRAC_W:0] opB,
  output logic                  busy,
  output logic                  done,
  output logic [EXP_W+FRAC_W:0] result,
  output logic                  ovf,
  output logic                  unf
);

  fpmStrobes_t stb;

  fpm_ctrl #(.MAN_W(FRAC_W + 1)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .stb   (stb),
    .busy  (busy)
  );

  fpm_dpath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .opA    (opA),
    .opB    (opB),
    .done   (done),
    .result (result),
    .ovf    (ovf),
    .unf    (unf)
  );

endmodule

// File: rtl/fpm_checker.sv
module fpm_checker #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  start,
  input logic                  sgnA,
  input logic                  sgnB,
  input logic                  busy,
  input logic                  done,
  input logic [EXP_W+FRAC_W:0] result,
  input logic                  ovf,
  input logic                  unf
);

  localparam int LAT   = FRAC_W + 5;
  localparam int TCW   = $clog2(LAT + 2);
  localparam int SGN_B = EXP_W + FRAC_W;

  logic [TCW-1:0] tCnt;
  logic           active;
  logic           capSgn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tCnt   <= '0;
      active <= 1'b0;
      capSgn <= 1'b0;
    end else if (start && !busy && !active) begin
      tCnt   <= '0;
      active <= 1'b1;
      capSgn <= sgnA ^ sgnB;
    end else if (done) begin
      active <= 1'b0;
    end else if (active) begin
      tCnt <= tCnt + 1'b1;
    end
  end

  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (active && tCnt == TCW'(LAT)));  // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R7
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);  // R7
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);  // R8
  AST_RESULT_SIGN: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (result[SGN_B] == capSgn));  // R3
  AST_OVERFLOW_INF: assert property (@(posedge clk) disable iff (!rstN)
    (done && ovf) |-> (result[SGN_B-1:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));  // R5
  AST_UNDERFLOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (done && unf) |-> (result[SGN_B-1:0] == '0));  // R6
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(ovf && unf));  // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(result) && $stable(ovf) && $stable(unf)));  // R10

endmodule

bind fp_mul_seq fpm_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_fpm_checker (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .sgnA   (opA[EXP_W+FRAC_W]),
  .sgnB   (opB[EXP_W+FRAC_W]),
  .busy   (busy),
  .done   (done),
  .result (result),
  .ovf    (ovf),
  .unf    (unf)
);

// File: tb/fp_mul_seq_bench.sv
`timescale 1ns/1ps
module fp_mul_seq_bench;

  localparam int LAT = 28;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        busy, done, ovf, unf;
  logic [31:0] result;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fp_mul_seq u_fp_mul_seq (
    .clk(clk), .rstN(rstN), .start(start), .opA(opA), .opB(opB),
    .busy(busy), .done(done), .result(result), .ovf(ovf), .unf(unf)
  );

  // reference arithmetic: {ovf, unf, result}
  function automatic logic [33:0] refMul(input logic [31:0] a, input logic [31:0] b);
    longint ma, mb, p, kept, rem, half;
    int e, sh;
    logic s;
    s = a[31] ^ b[31];
    if (a[30:23] == 8'd0 || b[30:23] == 8'd0) return {2'b00, s, 31'd0};
    ma = longint'({1'b1, a[22:0]});
    mb = longint'({1'b1, b[22:0]});
    p  = ma * mb;
    e  = int'(a[30:23]) + int'(b[30:23]) - 127;
    if (p >= (longint'(1) << 47)) begin sh = 24; e = e + 1; end
    else sh = 23;
    kept = p >> sh;
    rem  = p - (kept << sh);
    half = longint'(1) << (sh - 1);
    if (rem > half || (rem == half && (kept % 2) == 1)) kept = kept + 1;
    if (kept == (longint'(1) << 24)) begin kept = kept >> 1; e = e + 1; end
    if (e >= 255) return {2'b10, s, 8'hFF, 23'd0};
    if (e <= 0) return {2'b01, s, 31'd0};
    return {2'b00, s, e[7:0], kept[22:0]};
  endfunction

  // cycle-level reference model
  logic        mBusy, mDone, mOvf, mUnf;
  logic [31:0] mRes;
  logic [33:0] pend;
  int          mCnt;

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy <= 0; mDone <= 0; mOvf <= 0; mUnf <= 0; mRes <= '0; mCnt <= 0; pend <= '0;
    end else begin
      mDone <= 0;
      if (mCnt > 0) begin
        if (mCnt == 1) begin
          mBusy <= 0; mDone <= 1;
          {mOvf, mUnf, mRes} <= pend;
        end
        mCnt <= mCnt - 1;
      end else if (start) begin
        mBusy <= 1;
        mCnt  <= LAT;
        pend  <= refMul(opA, opB);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk(busy == mBusy, "R7 busy", 32'(busy), 32'(mBusy));
      chk(done == mDone, "R7 done", 32'(done), 32'(mDone));
      if (mDone) chk(result == mRes, "R1 result at done", result, mRes);
      else       chk(result == mRes, "R10 result hold", result, mRes);
      chk(ovf == mOvf, "R5 ovf flag", 32'(ovf), 32'(mOvf));
      chk(unf == mUnf, "R6 unf flag", 32'(unf), 32'(mUnf));
    end
  end

  task automatic waitDone();
    for (int i = 0; i < 100; i++) begin
      if (done) return;
      @(negedge clk);
    end
  endtask

  task automatic runOp(input logic [31:0] a, input logic [31:0] b, input logic [31:0] expRes,
                       input bit expO, input bit expU, input string tag);
    @(negedge clk);
    opA = a; opB = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone();
    chk(done == 1'b1, {tag, " done seen"}, 32'(done), 32'd1);
    chk(result == expRes, {tag, " value"}, result, expRes);
    chk(ovf == expO, {tag, " ovf"}, 32'(ovf), 32'(expO));
    chk(unf == expU, {tag, " unf"}, 32'(unf), 32'(expU));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [33:0] r;
    repeat (4) @(negedge clk);
    // R9 reset state
    chk({busy, done, ovf, unf} == 4'b0, "R9 reset controls", 32'({busy, done, ovf, unf}), 32'd0);
    chk(result == 32'd0, "R9 reset result", result, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    runOp(32'h3F000000, 32'hBEE00000, 32'hBE600000, 0, 0, "R1 R3 0.5*-0.4375");
    runOp(32'h3FC00000, 32'h3FC00000, 32'h40100000, 0, 0, "R1 normalize 1.5*1.5");
    runOp(32'h3F800001, 32'h3FC00000, 32'h3FC00002, 0, 0, "R2 tie to even up");
    runOp(32'h3F800003, 32'h3FC00000, 32'h3FC00004, 0, 0, "R2 tie to even down");
    runOp(32'h3FFFFFFE, 32'h3F800001, 32'h40000000, 0, 0, "R2 round carry renormalize");
    runOp(32'h80000000, 32'h3F800000, 32'h80000000, 0, 0, "R4 R3 negative zero operand");
    runOp(32'h00000000, 32'hC0000000, 32'h80000000, 0, 0, "R4 zero times negative");
    runOp(32'h7F7FFFFF, 32'h00000000, 32'h00000000, 0, 0, "R4 zero suppresses overflow");
    runOp(32'h7F000000, 32'h7F000000, 32'h7F800000, 1, 0, "R5 overflow");
    runOp(32'hFF000000, 32'h7F000000, 32'hFF800000, 1, 0, "R5 R3 negative overflow");
    runOp(32'h7F000000, 32'h3F800000, 32'h7F000000, 0, 0, "R5 exponent 254 normal");
    runOp(32'h00800000, 32'h00800000, 32'h00000000, 0, 1, "R6 underflow");
    runOp(32'h80800000, 32'h00800000, 32'h80000000, 0, 1, "R6 R3 negative underflow");
    runOp(32'h20000000, 32'h20000000, 32'h00800000, 0, 0, "R6 exponent 1 normal");

    // R8: second start while busy is ignored
    @(negedge clk);
    opA = 32'h40400000; opB = 32'h40000000; start = 1'b1;   // 3*2 = 6
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    opA = 32'h3F800000; opB = 32'h3F800000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone();
    chk(result == 32'h40C00000, "R8 start while busy ignored", result, 32'h40C00000);
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R8 no second operation", 32'({busy, done}), 32'd0);

    // R1 R2 R3 varied operands against reference arithmetic
    for (int k = 0; k < 30; k++) begin
      logic [31:0] a, b;
      a = {1'($urandom), 8'($urandom_range(100, 154)), 23'($urandom)};
      b = {1'($urandom), 8'($urandom_range(100, 154)), 23'($urandom)};
      r = refMul(a, b);
      runOp(a, b, r[31:0], r[33], r[32], "R1 R2 R3 varied operands");
    end

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule